// File: doc/BRIEF.md
# Paired-Lane Sample Queue Distributor

This block sits between a high-rate converter capture path and a bank of two-input complex transform cores. On every write clock the capture side presents a wide word made of one 8-bit sample per lane. The block keeps one queue per lane and carries the samples across to a read clock that runs at half the write rate. On the read side it pulls two samples per cycle from every lane, so the sample throughput on both sides is the same.

Lanes are used in pairs so that one complex core can transform two independent real streams. In each pair the even lane goes to the core's real ports and the odd lane to its imaginary ports. All lanes advance together, so every core gets samples with the same time index on the same read cycle. A strobe marks the first word of each transform frame. A sticky flag in the write domain reports that a sample was lost because a queue was full.

Top module: `lane_pair_distributor`

## Requirements
- R1: `in_samples` holds one 8-bit sample per lane, with lane i in bits [8i+7:8i]. A beat is taken only in a cycle where `in_valid` is high.
- R2: Each lane has its own queue. Two successive accepted samples of a lane form one 16-bit word, with the earlier sample in bits [15:8] and the later sample in bits [7:0]. Cycles with `in_valid` low do not break a pair.
- R3: Core k receives lane 2k on `re_word` bits [16k+15:16k] and lane 2k+1 on `im_word` bits [16k+15:16k].
- R4: `out_valid` stays low while the queues hold no word. Words leave in the order they were written, and none is dropped or repeated while the queues do not overflow.
- R5: `frame_start` is high together with `out_valid` on the first word of every frame, which is every FRAME/2 output words counted from reset, and low at all other times.
- R6: `overflow` goes high after a word is written to a full queue. It then stays high until `wr_rst_n` is asserted.
- R7: All lanes are read in lockstep. Every output word in one cycle carries the same two sample indices.
- R8: After reset `out_valid`, `frame_start` and `overflow` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Capture-side clock |
| wr_rst_n | input | 1 | Active-low asynchronous reset, write domain |
| in_valid | input | 1 | Qualifies the capture beat |
| in_samples | input | LANES*8 | One 8-bit sample per lane |
| rd_clk | input | 1 | Core-side clock, half the write rate |
| rd_rst_n | input | 1 | Active-low asynchronous reset, read domain |
| re_word | output | LANES/2*16 | Sample pair of the even lane of each pair |
| im_word | output | LANES/2*16 | Sample pair of the odd lane of each pair |
| out_valid | output | 1 | The output words are valid |
| frame_start | output | 1 | First word of a frame |
| overflow | output | 1 | Sticky flag for a write to a full queue |

## Verification
The frame strobe and the restart of reading after the queues have run empty can fall on the same output word. The bench provokes this by ending a stretch of gapped input exactly on a frame boundary. It then lets the queues drain completely and resumes writing. The scoreboard must then see `frame_start` on the very first word after the idle gap. It must also see the data of that word match the first pair written after the pause. Overflow is provoked by holding the read domain in reset while writing continues.

// File: rtl/dist_pkg.sv
package dist_pkg;
  localparam int SAMPLE_W = 8;
  localparam int PAIR_W   = 2 * SAMPLE_W;

  // binary to reflected Gray code
  function automatic logic [31:0] to_gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  // earlier sample in the upper byte, later in the lower byte
  function automatic logic [PAIR_W-1:0] pack_pair(input logic [SAMPLE_W-1:0] earlier,
                                                  input logic [SAMPLE_W-1:0] later);
    return {earlier, later};
  endfunction
endpackage

// File: rtl/pair_packer.sv
module pair_packer
  import dist_pkg::*;
#(
  parameter int LANES = 16
) (
  input  logic                      wr_clk,
  input  logic                      wr_rst_n,
  input  logic                      in_valid,
  input  logic [LANES*SAMPLE_W-1:0] in_samples,
  output logic                      pair_wr,
  output logic [LANES*PAIR_W-1:0]   pair_data
);
  logic second;

  always_ff @(posedge wr_clk or negedge wr_rst_n) begin
    if (!wr_rst_n) begin
      second  <= 1'b0;
      pair_wr <= 1'b0;
    end else begin
      pair_wr <= in_valid && second;
      if (in_valid) second <= !second;
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [SAMPLE_W-1:0] held;
    always_ff @(posedge wr_clk or negedge wr_rst_n) begin
      if (!wr_rst_n) begin
        held                          <= '0;
        pair_data[l*PAIR_W +: PAIR_W] <= '0;
      end else if (in_valid) begin
        if (!second) held <= in_samples[l*SAMPLE_W +: SAMPLE_W];
        else pair_data[l*PAIR_W +: PAIR_W] <= pack_pair(held, in_samples[l*SAMPLE_W +: SAMPLE_W]);
      end
    end
  end
endmodule

// File: rtl/gray_async_fifo.sv
module gray_async_fifo
  import dist_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int W     = 16
) (
  input  logic         wr_clk,
  input  logic         wr_rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic         full,
  input  logic         rd_clk,
  input  logic         rd_rst_n,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wbin, wgray, rbin, rgray;
  logic [PW-1:0] rq1, rq2, wq1, wq2;
  logic [PW-1:0] wbin_nx, wgray_nx, rbin_nx, rgray_nx;
  logic          wr_ok, rd_ok;

  assign wr_ok    = wr_en && !full;
  assign rd_ok    = rd_en && !empty;
  assign wbin_nx  = wbin + PW'(wr_ok);
  assign rbin_nx  = rbin + PW'(rd_ok);
  assign wgray_nx = PW'(to_gray(32'(wbin_nx)));
  assign rgray_nx = PW'(to_gray(32'(rbin_nx)));

  always_ff @(posedge wr_clk) begin
    if (wr_ok) mem[wbin[AW-1:0]] <= wr_data;
  end

  always_ff @(posedge wr_clk or negedge wr_rst_n) begin
    if (!wr_rst_n) begin
      wbin <= '0; wgray <= '0; full <= 1'b0;
      rq1  <= '0; rq2   <= '0;
    end else begin
      rq1   <= rgray;
      rq2   <= rq1;
      wbin  <= wbin_nx;
      wgray <= wgray_nx;
      full  <= (wgray_nx == {~rq2[PW-1:PW-2], rq2[PW-3:0]});
    end
  end

  always_ff @(posedge rd_clk or negedge rd_rst_n) begin
    if (!rd_rst_n) begin
      rbin <= '0; rgray <= '0; empty <= 1'b1;
      wq1  <= '0; wq2   <= '0;
    end else begin
      wq1   <= wgray;
      wq2   <= wq1;
      rbin  <= rbin_nx;
      rgray <= rgray_nx;
      empty <= (rgray_nx == wq2);
    end
  end

  assign rd_data = mem[rbin[AW-1:0]];
endmodule

// File: rtl/frame_marker.sv
module frame_marker #(
  parameter int WORDS = 512
) (
  input  logic rd_clk,
  input  logic rd_rst_n,
  input  logic advance,
  output logic first
);
  localparam int CW = (WORDS > 1) ? $clog2(WORDS) : 1;
  logic [CW-1:0] idx;

  always_ff @(posedge rd_clk or negedge rd_rst_n) begin
    if (!rd_rst_n) idx <= '0;
    else if (advance) idx <= (idx == CW'(WORDS - 1)) ? '0 : idx + 1'b1;
  end

  assign first = advance && (idx == '0);
endmodule

// File: rtl/lane_pair_distributor.sv
module lane_pair_distributor
  import dist_pkg::*;
#(
  parameter int LANES = 16,
  parameter int FRAME = 1024,
  parameter int DEPTH = 64
) (
  input  logic                            wr_clk,
  input  logic                            wr_rst_n,
  input  logic                            in_valid,
  input  logic [LANES*SAMPLE_W-1:0]       in_samples,
  input  logic                            rd_clk,
  input  logic                            rd_rst_n,
  output logic [(LANES/2)*PAIR_W-1:0]     re_word,
  output logic [(LANES/2)*PAIR_W-1:0]     im_word,
  output logic                            out_valid,
  output logic                            frame_start,
  output logic                            overflow
);
  localparam int CORES = LANES / 2;
  localparam int WPF   = FRAME / 2;

  logic                    pair_wr;
  logic [LANES*PAIR_W-1:0] pair_data;
  logic [LANES*PAIR_W-1:0] lane_dout;
  logic [LANES-1:0]        lane_full, lane_empty;
  logic                    full_write, any_empty, rd_go, first_word;

  pair_packer #(.LANES(LANES)) u_pack (
    .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .in_valid(in_valid),
    .in_samples(in_samples), .pair_wr(pair_wr), .pair_data(pair_data));

  for (genvar l = 0; l < LANES; l++) begin : g_q
    gray_async_fifo #(.DEPTH(DEPTH), .W(PAIR_W)) u_fifo (
      .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_en(pair_wr),
      .wr_data(pair_data[l*PAIR_W +: PAIR_W]), .full(lane_full[l]),
      .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_en(rd_go),
      .rd_data(lane_dout[l*PAIR_W +: PAIR_W]), .empty(lane_empty[l]));
  end

  // named events for the checker
  assign full_write = pair_wr && (|lane_full);
  assign any_empty  = |lane_empty;
  assign rd_go      = !any_empty;

  always_ff @(posedge wr_clk or negedge wr_rst_n) begin
    if (!wr_rst_n) overflow <= 1'b0;
    else if (full_write) overflow <= 1'b1;
  end

  frame_marker #(.WORDS(WPF)) u_frame (
    .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .advance(rd_go), .first(first_word));

  always_ff @(posedge rd_clk or negedge rd_rst_n) begin
    if (!rd_rst_n) begin
      out_valid   <= 1'b0;
      frame_start <= 1'b0;
    end else begin
      out_valid   <= rd_go;
      frame_start <= first_word;
    end
  end

  for (genvar k = 0; k < CORES; k++) begin : g_core
    always_ff @(posedge rd_clk or negedge rd_rst_n) begin
      if (!rd_rst_n) begin
        re_word[k*PAIR_W +: PAIR_W] <= '0;
        im_word[k*PAIR_W +: PAIR_W] <= '0;
      end else if (rd_go) begin
        re_word[k*PAIR_W +: PAIR_W] <= lane_dout[(2*k)*PAIR_W +: PAIR_W];
        im_word[k*PAIR_W +: PAIR_W] <= lane_dout[(2*k+1)*PAIR_W +: PAIR_W];
      end
    end
  end
endmodule

module lane_pair_distributor_chk (
  input logic wr_clk,
  input logic wr_rst_n,
  input logic rd_clk,
  input logic rd_rst_n,
  input logic out_valid,
  input logic frame_start,
  input logic overflow,
  input logic full_write,
  input logic any_empty
);
  p_frame_on_valid_r5: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    frame_start |-> out_valid);
  p_frame_single_r5: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    frame_start |=> !frame_start);
  p_read_needs_data_r4: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    out_valid |-> $past(!any_empty));
  p_overflow_set_r6: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    full_write |=> overflow);
  p_overflow_hold_r6: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    overflow |=> overflow);
endmodule

bind lane_pair_distributor lane_pair_distributor_chk u_chk (
  .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .rd_clk(rd_clk), .rd_rst_n(rd_rst_n),
  .out_valid(out_valid), .frame_start(frame_start), .overflow(overflow),
  .full_write(full_write), .any_empty(any_empty));

// File: tb/sim_lane_pair_distributor.sv
module sim_lane_pair_distributor;
  localparam int LANES = 16;
  localparam int CORES = LANES / 2;
  localparam int FRAME = 1024;
  localparam int DEPTH = 64;
  localparam int WPF   = FRAME / 2;
  localparam int OW    = CORES * 16;

  logic              wr_clk = 0, rd_clk = 0;
  logic              wr_rst_n = 0, rd_rst_n = 0;
  logic              in_valid = 0;
  logic [LANES*8-1:0] in_samples = '0;
  logic [OW-1:0]     re_word, im_word;
  logic              out_valid, frame_start, overflow;

  int checks = 0, fails = 0;
  int beat_idx = 0;
  int vcount = 0;
  bit mon_en = 0;
  int stray = 0;
  logic [OW-1:0] exp_re[$], exp_im[$];
  logic [LANES*8-1:0] prev_beat;

  lane_pair_distributor #(.LANES(LANES), .FRAME(FRAME), .DEPTH(DEPTH)) u0 (
    .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .in_valid(in_valid), .in_samples(in_samples),
    .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .re_word(re_word), .im_word(im_word),
    .out_valid(out_valid), .frame_start(frame_start), .overflow(overflow));

  always #2 wr_clk = ~wr_clk;
  initial begin #1; forever #4 rd_clk = ~rd_clk; end

  task automatic chk(input bit ok, input string req, input logic [OW-1:0] act, input logic [OW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] smp(input int lane, input int idx);
    return 8'((lane * 29 + idx * 7 + 3) & 8'hFF);
  endfunction

  // driver: one capture beat; every second accepted beat pushes expected words
  task automatic beat(input bit v);
    logic [LANES*8-1:0] b;
    logic [OW-1:0] er, ei;
    @(negedge wr_clk);
    for (int l = 0; l < LANES; l++) b[l*8 +: 8] = smp(l, beat_idx);
    in_valid   = v;
    in_samples = v ? b : ~b;
    if (v) begin
      if (beat_idx % 2 == 1) begin
        for (int k = 0; k < CORES; k++) begin
          er[k*16 +: 16] = {prev_beat[(2*k)*8 +: 8],   b[(2*k)*8 +: 8]};
          ei[k*16 +: 16] = {prev_beat[(2*k+1)*8 +: 8], b[(2*k+1)*8 +: 8]};
        end
        exp_re.push_back(er);
        exp_im.push_back(ei);
      end
      prev_beat = b;
      beat_idx++;
    end
  endtask

  // monitor / scoreboard
  always @(negedge rd_clk) begin
    if (mon_en && rd_rst_n) begin
      if (out_valid) begin
        if (exp_re.size() == 0) begin
          stray++;
          chk(0, "R4 word with nothing written", OW'(1), OW'(0));
        end else begin
          logic [OW-1:0] er, ei;
          er = exp_re.pop_front();
          ei = exp_im.pop_front();
          chk(re_word == er, "R1 R2 R3 R7 real lanes", re_word, er);
          chk(im_word == ei, "R1 R2 R3 R7 imaginary lanes", im_word, ei);
          chk(frame_start == (vcount % WPF == 0), "R5 frame strobe on valid word",
              OW'(frame_start), OW'(vcount % WPF == 0));
          vcount++;
        end
      end else begin
        chk(!frame_start, "R5 strobe without valid", OW'(frame_start), OW'(0));
      end
    end
  end

  task automatic drain();
    while (exp_re.size() != 0) @(negedge rd_clk);
    repeat (20) @(negedge rd_clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #400000;
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge wr_clk);
    wr_rst_n = 1; rd_rst_n = 1;
    @(negedge rd_clk);
    // R8 reset state
    chk(!out_valid, "R8 out_valid after reset", OW'(out_valid), OW'(0));
    chk(!frame_start, "R8 frame_start after reset", OW'(frame_start), OW'(0));
    chk(!overflow, "R8 overflow after reset", OW'(overflow), OW'(0));
    mon_en = 1;

    // R4: idle queues produce nothing
    repeat (50) @(negedge rd_clk);
    chk(stray == 0, "R4 idle output", OW'(stray), OW'(0));

    // continuous stream, two frames
    for (int i = 0; i < 2 * FRAME; i++) beat(1);
    // gapped stream, one frame, pairs straddle idle cycles (R2)
    for (int i = 0; beat_idx < 3 * FRAME; i++) beat((i % 3) != 2);
    beat(0);
    // let the queues run empty exactly at a frame boundary
    drain();
    chk(vcount == 3 * WPF, "R5 words before pause", OW'(vcount), OW'(3 * WPF));
    // resume: first word after the gap must carry the frame strobe
    for (int i = 0; i < FRAME; i++) beat((i % 5) != 4 || i > FRAME - 8);
    while (beat_idx < 4 * FRAME) beat(1);
    beat(0);
    drain();
    chk(exp_re.size() == 0, "R4 all words delivered", OW'(exp_re.size()), OW'(0));
    chk(vcount == 4 * WPF, "R4 word count", OW'(vcount), OW'(4 * WPF));
    chk(stray == 0, "R4 no extra words", OW'(stray), OW'(0));
    chk(!overflow, "R6 no overflow in balanced flow", OW'(overflow), OW'(0));

    // R6: hold the reader in reset so the queues fill, then keep writing
    mon_en = 0;
    @(negedge rd_clk);
    rd_rst_n = 0;
    @(negedge rd_clk);
    chk(!out_valid, "R8 out_valid in read reset", OW'(out_valid), OW'(0));
    for (int i = 0; i < 2 * DEPTH - 8; i++) beat(1);
    beat(0);
    repeat (4) @(negedge wr_clk);
    chk(!overflow, "R6 not yet full", OW'(overflow), OW'(0));
    for (int i = 0; i < 24; i++) beat(1);
    beat(0);
    repeat (4) @(negedge wr_clk);
    chk(overflow, "R6 overflow set", OW'(overflow), OW'(1));
    repeat (40) @(negedge wr_clk);
    chk(overflow, "R6 overflow held", OW'(overflow), OW'(1));
    wr_rst_n = 0;
    @(negedge wr_clk);
    chk(!overflow, "R6 overflow cleared by reset", OW'(overflow), OW'(0));
    finish_run();
  end
endmodule